// File: doc/BRIEF.md
# Fractional-N PLL Output Rate Calculator

This block works out the output frequency of a fractional-N PLL from the contents of its two divider control words and the reference frequency in Hz. A start pulse captures the inputs. The block pulls the multiplier, pre-divider, post-divider shift and signed fraction out of the words and forms a numerator and a denominator. A sequential shift-subtract divider then reduces the pair to a 64-bit rate in Hz, and a single-cycle done pulse marks the result.

Two modes are selectable. Integer mode uses only the multiplier. Fractional mode adds the signed fraction to the multiplier on a 65536 scale. A zero pre-divider does not start a division. Instead it raises an error flag and returns a zero rate one cycle after the start.

Top module: `pll_rate_calc`

## Requirements
- R1: The multiplier M is taken from bits 21:12 of `div_word_i`, the pre-divider P from bits 9:4, and the post-divider shift S from bits 2:0. The fraction K is bits 15:0 of `frac_word_i`, read as two's complement. All other bits of both words have no effect on the result.
- R2: With `frac_mode_i`=0, the rate is floor(Fin*M / (P << S)).
- R3: With `frac_mode_i`=1, the rate is floor(Fin*(M*65536 + K) / ((P*65536) << S)).
- R4: In fractional mode, when M*65536 + K is negative, the rate is 0 and `err_o` stays low.
- R5: An accepted start with P=0 raises `err_o` and `done_o` in the next cycle, and `rate_o` reads 0.
- R6: For P≠0, `done_o` is a one-cycle pulse in the 65th cycle after the cycle in which the start was accepted.
- R7: A start that arrives while `busy_o` is high is ignored. The result reflects only the inputs captured at the accepted start.
- R8: `busy_o` is high from the cycle after an accepted start with P≠0 until the cycle in which `done_o` rises, and `done_o` is never high together with `busy_o`.
- R9: While the block is idle and no start is given, `rate_o` and `err_o` keep their values.
- R10: After reset, `busy_o`, `done_o` and `err_o` are 0 and `rate_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, captured when idle |
| frac_mode_i | input | 1 | 0: integer mode, 1: fractional mode |
| div_word_i | input | 32 | Divider control word holding M, P and S |
| frac_word_i | input | 32 | Fraction control word holding K |
| fref_i | input | 32 | Reference frequency in Hz |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Last request had a zero pre-divider |
| rate_o | output | 64 | Computed output rate in Hz |

## Verification
The hardest situation to reach is a second start that lands mid-division and carries a zero pre-divider. If that start leaked through, it would both flag an error and cut the running division short. The bench raises such a start several cycles into a normal run. It then checks that the done strobe still comes at the full latency with the first request's quotient and no error. A negative fractional coefficient is also hard to reach, because it only occurs when M is zero and K is negative. Directed cases with M=0 and negative K cover it, alongside sweeps over M, P, S, K and reserved-bit patterns.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;
  // Field placement inside the control words (bit positions are behaviour).
  localparam int M_LSB = 12;
  localparam int M_W   = 10;
  localparam int P_LSB = 4;
  localparam int P_W   = 6;
  localparam int S_LSB = 0;
  localparam int S_W   = 3;
  localparam int K_W   = 16;   // fraction width, also the fixed-point scale shift

  typedef struct packed {
    logic [M_W-1:0] mult;
    logic [P_W-1:0] prediv;
    logic [S_W-1:0] postsh;
    logic [K_W-1:0] frac;
  } pll_fields_t;
endpackage

// File: rtl/pll_rate_decode.sv
module pll_rate_decode
  import pll_rate_pkg::*;
#(
  parameter int CW     = 32,
  parameter int FIN_W  = 32,
  parameter int RATE_W = 64
) (
  input  logic [CW-1:0]     div_word_i,
  input  logic [CW-1:0]     frac_word_i,
  input  logic [FIN_W-1:0]  fref_i,
  input  logic              frac_mode_i,
  output logic [RATE_W-1:0] num_o,
  output logic [RATE_W-1:0] den_o,
  output logic              p_zero_o
);
  localparam int COEF_W = M_W + K_W + 1;

  pll_fields_t              fld;
  logic [COEF_W-1:0]        coef;
  logic [COEF_W-2:0]        coef_pos;
  logic [COEF_W-2:0]        mult_sel;
  logic [RATE_W-1:0]        den_base;
  logic                     unused_bits;

  always_comb begin
    fld.mult   = div_word_i[M_LSB +: M_W];
    fld.prediv = div_word_i[P_LSB +: P_W];
    fld.postsh = div_word_i[S_LSB +: S_W];
    fld.frac   = frac_word_i[K_W-1:0];

    // M*65536 + sign-extended K, evaluated as two's complement
    coef = {1'b0, fld.mult, {K_W{1'b0}}}
         + {{(COEF_W-K_W){fld.frac[K_W-1]}}, fld.frac};
    coef_pos = coef[COEF_W-1] ? '0 : coef[COEF_W-2:0];

    mult_sel = frac_mode_i ? coef_pos : (COEF_W-1)'(fld.mult);
    num_o    = RATE_W'(fref_i) * RATE_W'(mult_sel);

    den_base = frac_mode_i ? (RATE_W'(fld.prediv) << K_W) : RATE_W'(fld.prediv);
    den_o    = den_base << fld.postsh;
    p_zero_o = (fld.prediv == '0);
  end

  assign unused_bits = ^{div_word_i[CW-1:M_LSB+M_W], div_word_i[M_LSB-1:P_LSB+P_W],
                         div_word_i[P_LSB-1:S_LSB+S_W], frac_word_i[CW-1:K_W]};
endmodule

// File: rtl/pll_rate_div.sv
module pll_rate_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int              CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     acc_q, acc_d;   // holds the dividend, then the quotient
  logic [W-1:0]     den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             step_en;
  logic [W:0]       rem_sh;
  logic [W:0]       diff;
  logic             fits;

  assign step_en = load_i | busy_q;

  always_comb begin
    rem_sh = {rem_q, acc_q[W-1]};
    diff   = rem_sh - {1'b0, den_q};
    fits   = ~diff[W];
    rem_d  = rem_q;
    acc_d  = acc_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (busy_q) begin
      rem_d = fits ? diff[W-1:0] : rem_sh[W-1:0];
      acc_d = {acc_q[W-2:0], fits};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (load_i) begin
      rem_d  = '0;
      acc_d  = num_i;
      den_d  = den_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      acc_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (step_en) begin
        rem_q  <= rem_d;
        acc_q  <= acc_d;
        den_q  <= den_d;
        cnt_q  <= cnt_d;
        busy_q <= busy_d;
      end
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = acc_q;

  // R6: each busy cycle advances the step counter by one
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R6: the final step ends the run with a done strobe
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (!busy_q && done_q));
  // R6: done lasts exactly one cycle
  p_done_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int CW     = 32,
  parameter int FIN_W  = 32,
  parameter int RATE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              frac_mode_i,
  input  logic [CW-1:0]     div_word_i,
  input  logic [CW-1:0]     frac_word_i,
  input  logic [FIN_W-1:0]  fref_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [RATE_W-1:0] rate_o
);
  logic [RATE_W-1:0] num;
  logic [RATE_W-1:0] den;
  logic [RATE_W-1:0] quot;
  logic              p_zero;
  logic              div_busy;
  logic              div_done;
  logic              start_ok;
  logic              go;
  logic              err_q, err_d;
  logic              edone_q, edone_d;

  pll_rate_decode #(.CW(CW), .FIN_W(FIN_W), .RATE_W(RATE_W)) u_decode (
    .div_word_i  (div_word_i),
    .frac_word_i (frac_word_i),
    .fref_i      (fref_i),
    .frac_mode_i (frac_mode_i),
    .num_o       (num),
    .den_o       (den),
    .p_zero_o    (p_zero)
  );

  pll_rate_div #(.W(RATE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (go),
    .num_i  (num),
    .den_i  (den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quot_o (quot)
  );

  always_comb begin
    start_ok = start_i & ~div_busy;
    go       = start_ok & ~p_zero;
    err_d    = start_ok ? p_zero : err_q;
    edone_d  = start_ok & p_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      edone_q <= 1'b0;
    end else begin
      if (start_ok) err_q <= err_d;
      edone_q <= edone_d;
    end
  end

  assign busy_o = div_busy;
  assign done_o = div_done | edone_q;
  assign err_o  = err_q;
  assign rate_o = err_q ? '0 : quot;

  // R5: zero pre-divider answers in the next cycle with error and zero rate
  p_pzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && p_zero) |=> (done_o && err_o && rate_o == '0));
  // R7: no start can raise the error flag during a division
  p_busy_noerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !err_o);
  // R8: done and busy are never high together
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R9: idle without start holds the result
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(rate_o) && $stable(err_o)));
endmodule

// File: tb/pll_rate_calc_bench.sv
module pll_rate_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        frac_mode_i;
  logic [31:0] div_word_i;
  logic [31:0] frac_word_i;
  logic [31:0] fref_i;
  logic        busy_o;
  logic        done_o;
  logic        err_o;
  logic [63:0] rate_o;

  int total = 0;
  int bad   = 0;

  localparam int LAT_OK  = 65;
  localparam int LAT_ERR = 1;

  always #2.5 clk = ~clk;

  pll_rate_calc u_pll_rate_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_mode_i(frac_mode_i),
    .div_word_i(div_word_i), .frac_word_i(frac_word_i), .fref_i(fref_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rate_o(rate_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkdw(input int m, input int p, input int s, input bit junk);
    logic [31:0] w;
    w = junk ? 32'hFFC0_0C08 : 32'h0;
    w[21:12] = 10'(m);
    w[9:4]   = 6'(p);
    w[2:0]   = 3'(s);
    return w;
  endfunction

  function automatic logic [63:0] ref_rate(input logic [31:0] dw, input logic [31:0] fw,
                                           input logic [31:0] fin, input bit fm);
    logic [63:0] m, p, s, num, den;
    longint coef;
    m = 64'(dw[21:12]);
    p = 64'(dw[9:4]);
    s = 64'(dw[2:0]);
    if (p == 0) return 64'd0;
    if (!fm) begin
      num = 64'(fin) * m;
      den = p << s;
    end else begin
      coef = longint'(m) * 65536 + longint'($signed(fw[15:0]));
      num  = (coef < 0) ? 64'd0 : 64'(fin) * 64'(coef);
      den  = (p * 64'd65536) << s;
    end
    return num / den;
  endfunction

  task automatic run(input logic [31:0] dw, input logic [31:0] fw, input logic [31:0] fin,
                     input bit fm, output logic [63:0] r, output bit e, output int lat,
                     output bit busy1);
    @(negedge clk);
    div_word_i = dw; frac_word_i = fw; fref_i = fin; frac_mode_i = fm; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    div_word_i = 32'hDEAD_BEEF; frac_word_i = 32'h1234_8001; fref_i = 32'h5555_5555;
    busy1 = busy_o;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    r = rate_o;
    e = err_o;
  endtask

  task automatic run_chk(input string req, input logic [31:0] dw, input logic [31:0] fw,
                         input logic [31:0] fin, input bit fm);
    logic [63:0] r; bit e; int lat; bit b1;
    run(dw, fw, fin, fm, r, e, lat, b1);
    chk({req, " rate"}, r, ref_rate(dw, fw, fin, fm));
    chk({req, " err"}, 64'(e), 64'(dw[9:4] == 0));
    chk({req, " R6 latency"}, 64'(lat), (dw[9:4] == 0) ? 64'(LAT_ERR) : 64'(LAT_OK));
  endtask

  initial begin
    #(5ns * 150000);
    bad++; total++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mlist[4] = '{1, 225, 512, 1023};
    int plist[5] = '{1, 2, 3, 7, 63};
    int klist[5] = '{0, 9437, -1, 32767, -32768};
    logic [63:0] r, r0; bit e; int lat; bit b1;

    rst_n = 1'b0; start_i = 1'b0; frac_mode_i = 1'b0;
    div_word_i = '0; frac_word_i = '0; fref_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", 64'(busy_o), 0);
    chk("R10 done", 64'(done_o), 0);
    chk("R10 err",  64'(err_o), 0);
    chk("R10 rate", rate_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 known integer case: 24 MHz * 225 / 3
    run(mkdw(225, 3, 0, 0), 32'h0, 32'd24_000_000, 1'b0, r, e, lat, b1);
    chk("R2 1.8GHz", r, 64'd1_800_000_000);
    chk("R8 busy after start", 64'(b1), 1);
    chk("R8 busy at done", 64'(busy_o), 0);
    chk("R6 latency", 64'(lat), LAT_OK);
    @(negedge clk);
    chk("R6 done single", 64'(done_o), 0);

    // R3 known fractional case near 393.216 MHz
    run(mkdw(262, 2, 3, 0), 32'd9437, 32'd24_000_000, 1'b1, r, e, lat, b1);
    chk("R3 393.216MHz", r, ref_rate(mkdw(262, 2, 3, 0), 32'd9437, 32'd24_000_000, 1'b1));
    chk("R3 393.216MHz band", 64'(r >= 64'd393_215_000 && r <= 64'd393_216_000), 1);

    // R9 hold while idle
    repeat (10) @(negedge clk);
    chk("R9 rate hold", rate_o, r);
    chk("R9 err hold", 64'(err_o), 0);

    // R1 reserved bits have no effect
    run(mkdw(225, 3, 0, 1), 32'hFFFF_0000, 32'd24_000_000, 1'b1, r, e, lat, b1);
    chk("R1 reserved bits", r, 64'd1_800_000_000);

    // R5 zero pre-divider, both modes
    run_chk("R5 int", mkdw(100, 0, 2, 0), 32'h0, 32'd24_000_000, 1'b0);
    run(mkdw(100, 0, 2, 1), 32'd77, 32'd24_000_000, 1'b1, r, e, lat, b1);
    chk("R5 frac rate", r, 0);
    chk("R5 frac err", 64'(e), 1);
    chk("R5 frac latency", 64'(lat), LAT_ERR);
    repeat (5) @(negedge clk);
    chk("R9 err hold", 64'(err_o), 1);

    // R4 negative coefficient
    run(mkdw(0, 3, 0, 0), 32'hFFFF_FFFB, 32'd24_000_000, 1'b1, r, e, lat, b1);
    chk("R4 negative rate", r, 0);
    chk("R4 negative err", 64'(e), 0);
    run_chk("R4 M0 K-32768", mkdw(0, 1, 0, 0), 32'h0000_8000, 32'hFFFF_FFFF, 1'b1);
    run_chk("R4 M1 K-32768", mkdw(1, 1, 0, 0), 32'h0000_8000, 32'hFFFF_FFFF, 1'b1);

    // R7 start during busy carrying P=0 and other values
    @(negedge clk);
    div_word_i = mkdw(225, 3, 0, 0); frac_word_i = 0; fref_i = 32'd24_000_000;
    frac_mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (10) begin @(negedge clk); lat++; end
    div_word_i = mkdw(5, 0, 1, 0); frac_mode_i = 1'b1; start_i = 1'b1;
    @(negedge clk); lat++;
    start_i = 1'b0;
    chk("R7 busy kept", 64'(busy_o), 1);
    chk("R7 no err", 64'(err_o), 0);
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    chk("R7 latency", 64'(lat), LAT_OK);
    chk("R7 first result", rate_o, 64'd1_800_000_000);
    chk("R7 err", 64'(err_o), 0);

    // extremes
    run_chk("R3 max", mkdw(1023, 1, 0, 0), 32'h0000_7FFF, 32'hFFFF_FFFF, 1'b1);
    run_chk("R2 max", mkdw(1023, 1, 0, 0), 32'h0, 32'hFFFF_FFFF, 1'b0);
    r0 = rate_o;
    chk("R2 max value", r0, 64'(32'hFFFF_FFFF) * 64'd1023);

    // sweeps
    for (int mi = 0; mi < 4; mi++)
      for (int pi = 0; pi < 5; pi++)
        for (int s = 0; s < 8; s++) begin
          run_chk("R2 sweep", mkdw(mlist[mi], plist[pi], s, s[0]), 32'h0,
                  (s[1] ? 32'hFFFF_FFFF : 32'd24_000_000), 1'b0);
          for (int ki = 0; ki < 5; ki++)
            run_chk("R3 sweep", mkdw(mlist[mi], plist[pi], s, ki[0]),
                    {16'hA5C3, 16'(klist[ki])}, 32'd19_200_000 + 32'(ki * 1234567), 1'b1);
        end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule